// File: doc/BRIEF.md
# I/O Address Space Access Checker

This block screens every load and store aimed at the 40-bit physical I/O window. It looks at the top byte of the address to classify each request. A request is either carried out against a small backing register file, dropped while still reporting success, or answered with an error indication. Reads also return data. One fixed address inside the clock-control region gives fresh pseudo-random data on every read.

Two mode straps change how requests are handled. Permissive mode reports success for everything and carries out nearly every access. Fail-hard mode latches a fatal flag on the first error-class access. Each accepted request gets exactly one response, registered one cycle later.

Top module: `io_access_checker`

## Requirements
- R1: Every cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next clock; there is no response without a request. Write responses carry all-zero `rsp_rdata`.
- R2: Address bits [2:0] are ignored, so all accesses are treated as 8-byte aligned.
- R3: Regions (address bits [39:32]) 0x80, 0x81, 0x83, 0x84, 0x85, 0x86, 0x88, 0x89, 0x90 and 0xC0 to 0xCF are read and written with `rsp_ok`=1. All of them share one 16-entry store indexed by address bits [6:3], and every entry resets to zero.
- R4: On a carried-out write, mask bit i enables data byte i (bits 8i+7 to 8i); bytes whose mask bit is clear keep their old value.
- R5: Regions 0x82, 0x87, 0x8A to 0x8F, 0x91 to 0x9F and 0xD0 to 0xFE (and anything below 0x80) answer with `rsp_ok`=0 and change no storage. A read of them returns 0xDEADDEADDEADDEAD. In region 0x82 this read value holds in both modes.
- R6: A request to regions 0xA0 to 0xBF raises `misroute` together with its response. It gives `rsp_ok`=1, changes no storage, and a read returns 0xDEADDEADDEADDEAD.
- R7: Region 0xFF is read from the store with `rsp_ok`=1. A write there is dropped and answered with `rsp_ok`=0.
- R8: A read of address 0x83_0000_0030 returns pseudo-random data that changes on every such read. A write to that address changes no storage and gives `rsp_ok`=1.
- R9: With `mode_permissive`=1, every response has `rsp_ok`=1. Reads use the store in every region except 0x82, and writes go to the store in every region except 0xFF.
- R10: With `mode_fail_hard`=1, a request that would get `rsp_ok`=0 without permissive mode sets `fatal_viol`. The flag then stays high until reset. Without fail-hard mode it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_read | input | 1 | 1 = load, 0 = store |
| req_addr | input | 40 | Physical I/O address |
| req_wdata | input | 64 | Store data |
| req_bmask | input | 8 | Store byte enables |
| mode_permissive | input | 1 | Accept and carry out (nearly) everything |
| mode_fail_hard | input | 1 | Latch fatal flag on error-class access |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Load data |
| rsp_ok | output | 1 | 1 = success, 0 = error indication |
| fatal_viol | output | 1 | Sticky fatal violation |
| misroute | output | 1 | Request hit a region that should never arrive |

## Verification
The in-RTL assertions watch the properties that hold on every cycle:
- the one-cycle request-to-response pairing;
- stickiness of the fatal flag, and that it stays low without fail-hard;
- success under permissive mode;
- misroute only accompanying a successful response;
- the filler pattern for region 0x82.

Other behaviours need a history of stores and loads, so only the bench scenarios can show them: shared-index aliasing, byte-mask merging, dropped writes leaving earlier data intact, read-only behaviour of 0xFF, and the random register changing between reads.

// File: rtl/io_chk_pkg.sv
package io_chk_pkg;

   typedef struct packed {
      logic allow;     // plain read/write region
      logic misroute;  // region that must never reach this block
      logic rom;       // read-only region
      logic hole;      // reserved hole excluded even in permissive reads
      logic rng;       // exact random-register address
   } io_class_t;

   localparam logic [7:0] ROM_REGION  = 8'hFF;
   localparam logic [7:0] HOLE_REGION = 8'h82;

endpackage

// File: rtl/io_region_decode.sv
module io_region_decode
   import io_chk_pkg::*;
#(
   parameter int                ADDR_W   = 40,
   parameter logic [ADDR_W-1:0] RNG_ADDR = 40'h83_0000_0030
) (
   input  logic [ADDR_W-1:0] addr_al,
   output io_class_t         cls
);
   localparam int RTOP = ADDR_W - 1;

   logic [7:0] region;
   logic       fixed_hit;

   assign region = addr_al[RTOP -: 8];

   always_comb begin
      unique case (region)
         8'h80, 8'h81, 8'h83, 8'h84, 8'h85,
         8'h86, 8'h88, 8'h89, 8'h90:        fixed_hit = 1'b1;
         default:                           fixed_hit = 1'b0;
      endcase
   end

   always_comb begin
      cls          = '0;
      cls.allow    = fixed_hit | (region[7:4] == 4'hC);
      cls.misroute = (region[7:5] == 3'b101);
      cls.rom      = (region == ROM_REGION);
      cls.hole     = (region == HOLE_REGION);
      cls.rng      = (addr_al == RNG_ADDR);
   end

endmodule

// File: rtl/io_reg_store.sv
module io_reg_store #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    idx,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] bmask,
   output logic [DATA_W-1:0]   rdata
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("io_reg_store: DATA_W must be a multiple of 8");
      end
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_depth
         $error("io_reg_store: IDX_W must be 1..8");
      end
   endgenerate

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         logic [7:0] lane_mem [DEPTH];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < DEPTH; k++) lane_mem[k] <= 8'h00;
            end else if (wr_en && bmask[g]) begin
               lane_mem[idx] <= wdata[8*g +: 8];
            end
         end

         assign rdata[8*g +: 8] = lane_mem[idx];
      end
   endgenerate

endmodule

// File: rtl/io_rand_src.sv
module io_rand_src #(
   parameter int                W    = 64,
   parameter logic [W-1:0]      TAPS = 64'hD800_0000_0000_0000,
   parameter logic [W-1:0]      SEED = 64'h0123_4567_89AB_CDEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   output logic [W-1:0] value
);
   generate
      if (SEED == '0) begin : g_bad_seed
         $error("io_rand_src: SEED must be non-zero");
      end
      if (TAPS[W-1] != 1'b1) begin : g_bad_taps
         $error("io_rand_src: TAPS must include the top bit");
      end
   endgenerate

   logic [W-1:0] state_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       state_q <= SEED;
      else if (advance) state_q <= state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);
   end

   assign value = state_q;

endmodule

// File: rtl/io_access_checker.sv
module io_access_checker
   import io_chk_pkg::*;
#(
   parameter int                ADDR_W   = 40,
   parameter int                DATA_W   = 64,
   parameter int                IDX_W    = 4,
   parameter logic [ADDR_W-1:0] RNG_ADDR = 40'h83_0000_0030
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_read,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [DATA_W/8-1:0] req_bmask,
   input  logic                mode_permissive,
   input  logic                mode_fail_hard,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                rsp_ok,
   output logic                fatal_viol,
   output logic                misroute
);
   localparam int                ALIGN_B   = 3;
   localparam logic [DATA_W-1:0] DEAD_FILL = {(DATA_W/16){16'hDEAD}};

   generate
      if (DATA_W % 16 != 0) begin : g_bad_data
         $error("io_access_checker: DATA_W must be a multiple of 16");
      end
      if (ADDR_W < ALIGN_B + IDX_W + 8) begin : g_bad_addr
         $error("io_access_checker: ADDR_W too small for region and index");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_al;
   io_class_t         cls;
   logic              norm_ok, do_rd, do_wr, rng_adv;
   logic [DATA_W-1:0] st_rdata, rnd_val, rd_next;

   assign addr_al = {req_addr[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};

   io_region_decode #(.ADDR_W(ADDR_W), .RNG_ADDR(RNG_ADDR)) u_decode (
      .addr_al (addr_al),
      .cls     (cls)
   );

   assign norm_ok = cls.allow | cls.misroute | (cls.rom & req_read);
   assign do_rd   = mode_permissive ? !cls.hole : (cls.allow | cls.rom);
   assign do_wr   = req_valid & !req_read & !cls.rng &
                    (mode_permissive ? !cls.rom : cls.allow);
   assign rng_adv = req_valid & req_read & cls.rng;

   io_reg_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (do_wr),
      .idx   (addr_al[ALIGN_B +: IDX_W]),
      .wdata (req_wdata),
      .bmask (req_bmask),
      .rdata (st_rdata)
   );

   io_rand_src #(.W(DATA_W)) u_rand (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (rng_adv),
      .value   (rnd_val)
   );

   always_comb begin
      if (!req_read)    rd_next = '0;
      else if (cls.rng) rd_next = rnd_val;
      else if (do_rd)   rd_next = st_rdata;
      else              rd_next = DEAD_FILL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         rsp_ok     <= 1'b0;
         misroute   <= 1'b0;
         fatal_viol <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         misroute  <= req_valid & cls.misroute;
         if (req_valid) begin
            rsp_rdata <= rd_next;
            rsp_ok    <= mode_permissive | norm_ok;
         end
         if (req_valid && mode_fail_hard && !norm_ok) fatal_viol <= 1'b1;
      end
   end

   // ---------------- assertions ----------------
   assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_hole_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_read && req_addr[ADDR_W-1 -: 8] == HOLE_REGION)
      |=> (rsp_rdata == DEAD_FILL));
   assert_misroute_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
      misroute |-> (rsp_valid && rsp_ok));
   assert_permissive_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode_permissive) |=> rsp_ok);
   assert_fatal_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_viol |=> fatal_viol);
   assert_fatal_needs_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_fail_hard && !fatal_viol) |=> !fatal_viol);

endmodule

// File: tb/io_access_checker_tb_top.sv
module io_access_checker_tb_top;

   localparam logic [63:0] DEAD = 64'hDEAD_DEAD_DEAD_DEAD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_read = 1'b0;
   logic [39:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [7:0]  req_bmask = '0;
   logic        mode_permissive = 1'b0;
   logic        mode_fail_hard = 1'b0;
   logic        rsp_valid, rsp_ok, fatal_viol, misroute;
   logic [63:0] rsp_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [63:0] r_data;
   logic        r_ok, r_valid, r_mis, r_fatal;

   always #10 clk = ~clk;   // 50 MHz

   io_access_checker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
      .mode_permissive(mode_permissive), .mode_fail_hard(mode_fail_hard),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok),
      .fatal_viol(fatal_viol), .misroute(misroute)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic access(input logic rd, input logic [39:0] a,
                         input logic [63:0] wd, input logic [7:0] m);
      @(negedge clk);
      req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = wd; req_bmask = m;
      @(negedge clk);
      req_valid = 1'b0;
      r_valid = rsp_valid; r_data = rsp_rdata; r_ok = rsp_ok;
      r_mis = misroute; r_fatal = fatal_viol;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "idle rsp_valid", {63'd0, rsp_valid}, 64'd0);
      check("R10", "reset fatal", {63'd0, fatal_viol}, 64'd0);
      check("R6", "reset misroute", {63'd0, misroute}, 64'd0);
      access(1'b1, 40'h80_0000_0000, '0, '0);
      check("R1", "read rsp_valid", {63'd0, r_valid}, 64'd1);
      check("R3", "reset store zero", r_data, 64'd0);
      @(negedge clk);
      check("R1", "single response", {63'd0, rsp_valid}, 64'd0);
   endtask

   task automatic t_allowed_rw();
      access(1'b0, 40'h80_0000_0008, 64'h1122_3344_5566_7788, 8'hFF);
      check("R3", "write ok", {63'd0, r_ok}, 64'd1);
      check("R1", "write rdata zero", r_data, 64'd0);
      access(1'b1, 40'h90_1234_0008, '0, '0);
      check("R3", "shared index read", r_data, 64'h1122_3344_5566_7788);
      access(1'b0, 40'hC7_0000_0013, 64'hB2B2_0000_1111_2222, 8'hFF);
      access(1'b1, 40'h84_0000_0016, '0, '0);
      check("R2", "low bits ignored", r_data, 64'hB2B2_0000_1111_2222);
      check("R3", "read ok", {63'd0, r_ok}, 64'd1);
   endtask

   task automatic t_bytemask();
      access(1'b0, 40'h85_0000_0008, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F);
      access(1'b1, 40'h80_0000_0008, '0, '0);
      check("R4", "low bytes merged", r_data, 64'h1122_3344_FFFF_FFFF);
      access(1'b0, 40'h86_0000_0008, 64'h0, 8'h00);
      access(1'b1, 40'h80_0000_0008, '0, '0);
      check("R4", "empty mask", r_data, 64'h1122_3344_FFFF_FFFF);
   endtask

   task automatic t_error();
      access(1'b1, 40'h82_0000_0008, '0, '0);
      check("R5", "hole read data", r_data, DEAD);
      check("R5", "hole read ok", {63'd0, r_ok}, 64'd0);
      access(1'b1, 40'hD5_0000_0008, '0, '0);
      check("R5", "0xD5 read data", r_data, DEAD);
      check("R5", "0xD5 read ok", {63'd0, r_ok}, 64'd0);
      access(1'b1, 40'h9F_0000_0008, '0, '0);
      check("R5", "0x9F read ok", {63'd0, r_ok}, 64'd0);
      access(1'b0, 40'h8A_0000_0008, 64'h0, 8'hFF);
      check("R5", "0x8A write ok", {63'd0, r_ok}, 64'd0);
      access(1'b1, 40'h80_0000_0008, '0, '0);
      check("R5", "dropped write", r_data, 64'h1122_3344_FFFF_FFFF);
      check("R10", "no fatal without mode", {63'd0, r_fatal}, 64'd0);
   endtask

   task automatic t_misroute();
      access(1'b1, 40'hA0_0000_0008, '0, '0);
      check("R6", "read data", r_data, DEAD);
      check("R6", "read ok", {63'd0, r_ok}, 64'd1);
      check("R6", "flag", {63'd0, r_mis}, 64'd1);
      access(1'b0, 40'hBF_0000_0008, 64'h0, 8'hFF);
      check("R6", "write flag", {63'd0, r_mis}, 64'd1);
      access(1'b1, 40'h80_0000_0008, '0, '0);
      check("R6", "no storage change", r_data, 64'h1122_3344_FFFF_FFFF);
      check("R6", "flag clears", {63'd0, r_mis}, 64'd0);
   endtask

   task automatic t_rom();
      access(1'b1, 40'hFF_0000_0008, '0, '0);
      check("R7", "rom read data", r_data, 64'h1122_3344_FFFF_FFFF);
      check("R7", "rom read ok", {63'd0, r_ok}, 64'd1);
      access(1'b0, 40'hFF_0000_0008, 64'h0, 8'hFF);
      check("R7", "rom write ok", {63'd0, r_ok}, 64'd0);
      access(1'b1, 40'h80_0000_0008, '0, '0);
      check("R7", "rom write dropped", r_data, 64'h1122_3344_FFFF_FFFF);
   endtask

   task automatic t_rng();
      logic [63:0] v1, v2;
      access(1'b1, 40'h83_0000_0030, '0, '0);
      v1 = r_data;
      check("R8", "rng ok", {63'd0, r_ok}, 64'd1);
      access(1'b1, 40'h83_0000_0034, '0, '0);
      v2 = r_data;
      check("R8", "rng changes", {63'd0, v1 != v2}, 64'd1);
      check("R8", "rng not filler", {63'd0, v1 != DEAD}, 64'd1);
      access(1'b0, 40'h80_0000_0030, 64'h6666_7777_8888_9999, 8'hFF);
      access(1'b0, 40'h83_0000_0030, 64'h0, 8'hFF);
      check("R8", "rng write ok", {63'd0, r_ok}, 64'd1);
      access(1'b1, 40'h80_0000_0030, '0, '0);
      check("R8", "rng write no storage", r_data, 64'h6666_7777_8888_9999);
   endtask

   task automatic t_permissive();
      mode_permissive = 1'b1;
      access(1'b1, 40'h82_0000_0020, '0, '0);
      check("R9", "hole read data", r_data, DEAD);
      check("R9", "hole read ok", {63'd0, r_ok}, 64'd1);
      access(1'b0, 40'hD0_0000_0020, 64'hC3C3_0101_0202_0303, 8'hFF);
      check("R9", "reserved write ok", {63'd0, r_ok}, 64'd1);
      access(1'b1, 40'hA0_0000_0020, '0, '0);
      check("R9", "misroute read performed", r_data, 64'hC3C3_0101_0202_0303);
      access(1'b0, 40'hFF_0000_0020, 64'h0, 8'hFF);
      check("R9", "rom write ok", {63'd0, r_ok}, 64'd1);
      access(1'b1, 40'h80_0000_0020, '0, '0);
      check("R9", "rom write still dropped", r_data, 64'hC3C3_0101_0202_0303);
      mode_permissive = 1'b0;
   endtask

   task automatic t_failhard();
      mode_fail_hard = 1'b1;
      access(1'b1, 40'h80_0000_0020, '0, '0);
      check("R10", "no fatal on good access", {63'd0, r_fatal}, 64'd0);
      access(1'b1, 40'h87_0000_0020, '0, '0);
      check("R10", "fatal on error", {63'd0, r_fatal}, 64'd1);
      mode_fail_hard = 1'b0;
      access(1'b1, 40'h80_0000_0020, '0, '0);
      check("R10", "fatal sticky", {63'd0, r_fatal}, 64'd1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_allowed_rw();
      t_bytemask();
      t_error();
      t_misroute();
      t_rom();
      t_rng();
      t_permissive();
      t_failhard();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule